// File: doc/BRIEF.md
# I2C Bus Master Transmitter with Command Queue

This block writes to I2C slaves. Software fills a small queue with 10-bit command words. Each word holds one byte and two sequencing flags: begin-transaction and end-transaction. The engine takes words from the queue and turns them into bus activity:

- a START condition, or a repeated START when a transaction is already open;
- the byte, sent most significant bit first, followed by the slave acknowledge clock;
- a STOP condition when the word asks for one.

When the queue runs dry after an acknowledge clock, the engine holds SCL low and raises a data-request interrupt until software writes more words. Both bus lines are open-drain. An output-enable of 1 pulls the line low, and the line reads back through its input. Two divisor registers set the length of the SCL high phase and of the SCL low phase, counted in system clocks.

A slave NACK sets a sticky error flag, empties the queue and ends the transfer with a STOP.

Top module: `i2c_cmd_master`

## Requirements
- R1: A write to register address 1 sets the SCL high-phase length and a write to address 2 sets the low-phase length. Each length is in system clocks, and values below 2 act as 2. A data-bit high phase lasts exactly that many clocks while the line reads high, and a data-bit low phase lasts exactly its length.
- R2: A write to address 0 pushes wr_data[9:0] as a command word: bits 7:0 are the byte, bit 8 is the begin flag and bit 9 is the end flag. While the bus is idle, a popped word with bit 8 set produces a START condition followed by its byte, sent MSB first. A popped word without bit 8 is discarded with no bus activity.
- R3: A word with both flags clear sends its byte within the open transaction, with no START or STOP around it.
- R4: After sending a word whose bit 9 is set, the master takes the acknowledge clock and then produces a STOP condition, leaving both lines released.
- R5: When a word with bit 8 set is popped while a transaction is open, a repeated START is produced with no STOP before it. Its byte follows.
- R6: If the queue is empty after an acknowledge clock of an open transaction, the master holds SCL low and asserts irq_tx_req until a word is written. It then continues with that word and drops irq_tx_req.
- R7: SDA is sampled at the end of the ninth SCL high phase. A high value (NACK) sets nack_flag, empties the queue and produces a STOP. nack_flag holds until the next word with bit 8 set is popped.
- R8: The master changes SDA only while SCL is low, except for the SDA edges of START and STOP conditions.
- R9: The queue holds 8 words and reports fifo_full and fifo_empty. A push while it is full is dropped.
- R10: While rst is high and afterwards, until a command arrives, scl_oe, sda_oe, irq_tx_req and nack_flag are 0, fifo_empty is 1 and fifo_full is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 queue push, 1 high divisor, 2 low divisor |
| wr_data | input | 10 | Write data |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| irq_tx_req | output | 1 | Queue empty while SCL is held mid-transaction |
| nack_flag | output | 1 | Sticky NACK status |
| fifo_full | output | 1 | Queue holds 8 words |
| fifo_empty | output | 1 | Queue holds no word |

## Verification
A bus-level slave model decodes every START, STOP and byte, and the decoded stream is compared with the stream expected from the words pushed. The divisor sweep runs a short transaction for every pair taken from the set {0, 1, 2, 3, 6}. It shows whether the clamp to 2 works and whether the high and low phases are mapped to the right registers, since a swap only shows when the two differ.

Further patterns each separate one behaviour from its neighbours:
- A lone address word followed by a late data word separates stalling from ending the transaction.
- Interleaved begin flags separate a repeated START from a STOP plus a START.
- A NACK on the address byte and a NACK on a data byte show that the queue is flushed and that no later byte leaks out.
- An overfilled queue shows the dropped ninth word missing from the bus.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int CMD_W = 10;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_BIT_LO, ST_BIT_HI, ST_WAIT,
    ST_RS_LO, ST_RS_HI, ST_STOP_LO, ST_STOP_HI, ST_STOP_END
  } i2cm_state_e;

  function automatic logic [7:0] cmd_byte(input logic [CMD_W-1:0] w);
    return w[7:0];
  endfunction

  function automatic logic cmd_begin(input logic [CMD_W-1:0] w);
    return w[8];
  endfunction

  function automatic logic cmd_end(input logic [CMD_W-1:0] w);
    return w[9];
  endfunction
endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  input  logic         flush,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  assign full  = (cnt == (AW+1)'(DEPTH));
  assign empty = (cnt == '0);
  assign head  = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/i2cm_phase_timer.sv
module i2cm_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;

  assign done = en && (cnt == limit - W'(1));

  always_ff @(posedge clk) begin
    if (rst || clear || done) cnt <= '0;
    else if (en)              cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master #(
  parameter int DIV_W   = 8,
  parameter int DEPTH   = 8,
  parameter int DIV_RST = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [9:0] wr_data,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       irq_tx_req,
  output logic       nack_flag,
  output logic       fifo_full,
  output logic       fifo_empty
);
  import i2cm_pkg::*;

  localparam logic [3:0] ACK_BIT = 4'd8;

  function automatic logic [DIV_W-1:0] phase_len(input logic [DIV_W-1:0] v);
    return (v < DIV_W'(2)) ? DIV_W'(2) : v;
  endfunction

  logic [DIV_W-1:0] div_hi_q, div_lo_q;
  i2cm_state_e      st_q, st_d;
  logic [3:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic             endf_q, endf_d;
  logic             sda_want, nack_q;
  logic             pop, flush, nack_set, start_pop;
  logic [CMD_W-1:0] head;
  logic             t_done, t_en, t_clear, lo_phase;
  logic [DIV_W-1:0] t_limit;

  // named events for the bound checker
  logic bus_idle, sda_edge_ok, ev_start_pop, ev_nack;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_hi_q <= DIV_W'(DIV_RST);
      div_lo_q <= DIV_W'(DIV_RST);
    end else if (wr_en) begin
      if (wr_addr == 2'd1) div_hi_q <= wr_data[DIV_W-1:0];
      if (wr_addr == 2'd2) div_lo_q <= wr_data[DIV_W-1:0];
    end
  end

  i2cm_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(wr_en && wr_addr == 2'd0), .push_data(wr_data),
    .pop(pop), .flush(flush),
    .head(head), .full(fifo_full), .empty(fifo_empty)
  );

  assign lo_phase = (st_q == ST_BIT_LO) || (st_q == ST_RS_LO) || (st_q == ST_STOP_LO);
  assign t_limit  = lo_phase ? phase_len(div_lo_q) : phase_len(div_hi_q);
  assign t_clear  = (st_q == ST_IDLE) || (st_q == ST_WAIT);
  always_comb begin
    case (st_q)
      ST_BIT_HI, ST_RS_HI, ST_STOP_HI: t_en = scl_in;
      ST_IDLE, ST_WAIT:                t_en = 1'b0;
      default:                         t_en = 1'b1;
    endcase
  end

  i2cm_phase_timer #(.W(DIV_W)) u_timer (
    .clk(clk), .rst(rst), .clear(t_clear), .en(t_en),
    .limit(t_limit), .done(t_done)
  );

  always_comb begin
    st_d = st_q; bit_d = bit_q; sh_d = sh_q; endf_d = endf_q;
    pop = 1'b0; flush = 1'b0; nack_set = 1'b0; start_pop = 1'b0;
    case (st_q)
      ST_IDLE: if (!fifo_empty) begin
        pop = 1'b1;
        if (cmd_begin(head)) begin
          start_pop = 1'b1;
          sh_d = cmd_byte(head); endf_d = cmd_end(head);
          st_d = ST_START;
        end
      end
      ST_START: if (t_done) begin st_d = ST_BIT_LO; bit_d = '0; end
      ST_BIT_LO: if (t_done) st_d = ST_BIT_HI;
      ST_BIT_HI: if (t_done) begin
        if (bit_q == ACK_BIT) begin
          if (sda_in) begin
            nack_set = 1'b1; flush = 1'b1; st_d = ST_STOP_LO;
          end else if (endf_q) begin
            st_d = ST_STOP_LO;
          end else if (fifo_empty) begin
            st_d = ST_WAIT;
          end else begin
            pop = 1'b1; sh_d = cmd_byte(head); endf_d = cmd_end(head);
            if (cmd_begin(head)) begin start_pop = 1'b1; st_d = ST_RS_LO; end
            else begin bit_d = '0; st_d = ST_BIT_LO; end
          end
        end else begin
          bit_d = bit_q + 4'd1; sh_d = {sh_q[6:0], 1'b0}; st_d = ST_BIT_LO;
        end
      end
      ST_WAIT: if (!fifo_empty) begin
        pop = 1'b1; sh_d = cmd_byte(head); endf_d = cmd_end(head);
        if (cmd_begin(head)) begin start_pop = 1'b1; st_d = ST_RS_LO; end
        else begin bit_d = '0; st_d = ST_BIT_LO; end
      end
      ST_RS_LO:    if (t_done) st_d = ST_RS_HI;
      ST_RS_HI:    if (t_done) st_d = ST_START;
      ST_STOP_LO:  if (t_done) st_d = ST_STOP_HI;
      ST_STOP_HI:  if (t_done) st_d = ST_STOP_END;
      ST_STOP_END: if (t_done) st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (st_q)
      ST_BIT_LO, ST_BIT_HI: sda_want = (bit_q != ACK_BIT) && !sh_q[7];
      ST_START, ST_STOP_LO, ST_STOP_HI: sda_want = 1'b1;
      default: sda_want = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE; bit_q <= '0; sh_q <= '0; endf_q <= 1'b0;
      sda_oe <= 1'b0; nack_q <= 1'b0;
    end else begin
      st_q <= st_d; bit_q <= bit_d; sh_q <= sh_d; endf_q <= endf_d;
      sda_oe <= sda_want;
      if (nack_set)       nack_q <= 1'b1;
      else if (start_pop) nack_q <= 1'b0;
    end
  end

  assign scl_oe       = (st_q == ST_BIT_LO) || (st_q == ST_WAIT) ||
                        (st_q == ST_RS_LO) || (st_q == ST_STOP_LO);
  assign irq_tx_req   = (st_q == ST_WAIT);
  assign nack_flag    = nack_q;
  assign bus_idle     = (st_q == ST_IDLE);
  assign sda_edge_ok  = (st_q == ST_START) || (st_q == ST_STOP_END);
  assign ev_start_pop = start_pop;
  assign ev_nack      = nack_set;
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic clk,
  input logic rst,
  input logic scl_oe,
  input logic sda_oe,
  input logic irq_tx_req,
  input logic nack_flag,
  input logic fifo_full,
  input logic fifo_empty,
  input logic bus_idle,
  input logic sda_edge_ok,
  input logic ev_start_pop,
  input logic ev_nack
);
  AST_SDA_MOVES_ONLY_LOW: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> sda_edge_ok); // R8

  AST_IRQ_HOLDS_SCL: assert property (@(posedge clk) disable iff (rst)
    irq_tx_req |-> scl_oe); // R6

  AST_NACK_FLUSHES: assert property (@(posedge clk) disable iff (rst)
    ev_nack |=> (fifo_empty && nack_flag && scl_oe)); // R7

  AST_NACK_CLEARS_ON_START: assert property (@(posedge clk) disable iff (rst)
    (!nack_flag && $past(nack_flag)) |-> $past(ev_start_pop)); // R7

  AST_FIFO_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(fifo_full && fifo_empty)); // R9

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    bus_idle |-> (!scl_oe && !sda_oe && !irq_tx_req)); // R10
endmodule

bind i2c_cmd_master i2cm_checker u_i2cm_checker (
  .clk(clk), .rst(rst), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .irq_tx_req(irq_tx_req), .nack_flag(nack_flag),
  .fifo_full(fifo_full), .fifo_empty(fifo_empty),
  .bus_idle(bus_idle), .sda_edge_ok(sda_edge_ok),
  .ev_start_pop(ev_start_pop), .ev_nack(ev_nack)
);

// File: tb/test_i2c_cmd_master.sv
module test_i2c_cmd_master;
  localparam int EV_S = 256;
  localparam int EV_P = 257;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [9:0] wr_data = '0;
  logic scl_oe, sda_oe, irq_tx_req, nack_flag, fifo_full, fifo_empty;
  logic slv_oe = 1'b0;
  logic scl_l, sda_l;

  assign scl_l = ~scl_oe;
  assign sda_l = ~(sda_oe | slv_oe);

  i2c_cmd_master i_i2c_cmd_master (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .scl_in(scl_l), .sda_in(sda_l), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .irq_tx_req(irq_tx_req), .nack_flag(nack_flag),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int bad = 0;
  int obs_q[$];
  int exp_q[$];
  int nack_val = -1;
  bit meas = 1'b0;
  int exp_hi = 2, exp_lo = 2;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // slave model and bus monitor, sampling between clock edges
  bit prev_scl = 1'b1, prev_sda = 1'b1, cond_in_run = 1'b0;
  int bitcnt = 0, run = 0;
  int shreg = 0;
  always @(negedge clk) begin
    if (rst) begin
      prev_scl = 1'b1; prev_sda = 1'b1; bitcnt = 0; run = 0; slv_oe = 1'b0;
    end else begin
      if (prev_scl && scl_l && prev_sda && !sda_l) begin
        obs_q.push_back(EV_S); bitcnt = 0; cond_in_run = 1'b1;
      end else if (prev_scl && scl_l && !prev_sda && sda_l) begin
        obs_q.push_back(EV_P); bitcnt = 0; cond_in_run = 1'b1;
      end
      if (scl_l == prev_scl) run++;
      else begin
        if (!prev_scl && scl_l) begin
          if (meas) chk(run == exp_lo, "R1 low phase", run, exp_lo);
          if (bitcnt < 8) shreg = ((shreg << 1) | int'(sda_l)) & 8'hFF;
          bitcnt++;
        end else begin
          if (meas && !cond_in_run) chk(run == exp_hi, "R1 high phase", run, exp_hi);
          if (bitcnt == 8) begin
            obs_q.push_back(shreg);
            slv_oe = (shreg != nack_val);
          end else if (bitcnt == 9) begin
            slv_oe = 1'b0; bitcnt = 0;
          end
        end
        run = 1; cond_in_run = 1'b0;
      end
      prev_scl = scl_l; prev_sda = sda_l;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 10'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_quiet(input int n);
    int q = 0;
    while (q < n) begin
      @(negedge clk);
      if (!scl_oe && !sda_oe && fifo_empty) q++; else q = 0;
    end
  endtask

  task automatic compare(input string req);
    chk(obs_q.size() == exp_q.size(), {req, " event count"}, obs_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < obs_q.size(); i++)
      chk(obs_q[i] == exp_q[i], {req, " bus event"}, obs_q[i], exp_q[i]);
    obs_q.delete(); exp_q.delete();
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(!scl_oe && !sda_oe, "R10 lines released in reset", {scl_oe, sda_oe}, 0);
    chk(!irq_tx_req && !nack_flag, "R10 flags clear in reset", {irq_tx_req, nack_flag}, 0);
    chk(fifo_empty && !fifo_full, "R10 R9 queue empty", {fifo_full, fifo_empty}, 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe && fifo_empty, "R10 idle after reset", {scl_oe, sda_oe}, 0);

    // R2 R3 R4: address 0x24 write, data 0x25, 0x13 then stop
    wr(1, 3); wr(2, 4);
    wr(0, 'h148); wr(0, 'h025); wr(0, 'h213);
    exp_q = '{EV_S, 'h48, 'h25, 'h13, EV_P};
    wait_quiet(40);
    compare("R2 R3 R4 basic write");

    // R1 R2 divisor sweep with clamp
    begin
      int vals[5] = '{0, 1, 2, 3, 6};
      for (int h = 0; h < 5; h++) begin
        for (int l = 0; l < 5; l++) begin
          int a = ((h * 37 + l * 11) & 'h7F) << 1;
          int d = (h * 53 + l * 29 + 5) & 'hFF;
          wr(1, vals[h]); wr(2, vals[l]);
          exp_hi = (vals[h] < 2) ? 2 : vals[h];
          exp_lo = (vals[l] < 2) ? 2 : vals[l];
          meas = 1'b1;
          wr(0, 'h100 | a); wr(0, 'h200 | d);
          exp_q = '{EV_S, a, d, EV_P};
          wait_quiet(40);
          meas = 1'b0;
          compare("R1 R2 sweep");
        end
      end
    end

    // R6 stall on empty queue after address byte
    wr(1, 2); wr(2, 2);
    wr(0, 'h148);
    repeat (200) @(negedge clk);
    chk(irq_tx_req == 1'b1, "R6 irq while stalled", irq_tx_req, 1);
    chk(scl_oe == 1'b1, "R6 SCL held low", scl_oe, 1);
    chk(obs_q.size() == 2, "R6 nothing sent after ack", obs_q.size(), 2);
    wr(0, 'h299);
    repeat (3) @(negedge clk);
    chk(irq_tx_req == 1'b0, "R6 irq drops after write", irq_tx_req, 0);
    exp_q = '{EV_S, 'h48, 'h99, EV_P};
    wait_quiet(20);
    compare("R6 resume");

    // R5 R8 repeated start
    wr(0, 'h150); wr(0, 'h011); wr(0, 'h162); wr(0, 'h233);
    exp_q = '{EV_S, 'h50, 'h11, EV_S, 'h62, 'h33, EV_P};
    wait_quiet(20);
    compare("R5 R8 repeated start");

    // R7 NACK on address flushes queue
    nack_val = 'hEE;
    wr(0, 'h1EE); wr(0, 'h001); wr(0, 'h002); wr(0, 'h203);
    exp_q = '{EV_S, 'hEE, EV_P};
    wait_quiet(20);
    compare("R7 nack on address");
    chk(nack_flag == 1'b1, "R7 nack flag set", nack_flag, 1);
    chk(fifo_empty == 1'b1, "R7 queue flushed", fifo_empty, 1);

    // R7 clear on new start, then NACK on data byte
    nack_val = 'h25;
    wr(0, 'h148); wr(0, 'h025); wr(0, 'h013); wr(0, 'h214);
    exp_q = '{EV_S, 'h48, 'h25, EV_P};
    wait_quiet(20);
    compare("R7 nack on data");
    chk(nack_flag == 1'b1, "R7 nack on data", nack_flag, 1);
    nack_val = -1;
    wr(0, 'h148); wr(0, 'h201);
    exp_q = '{EV_S, 'h48, 'h01, EV_P};
    wait_quiet(20);
    compare("R7 clean transfer");
    chk(nack_flag == 1'b0, "R7 flag cleared by start", nack_flag, 0);

    // R2 word without begin flag while idle is discarded
    wr(0, 'h077);
    repeat (50) @(negedge clk);
    chk(obs_q.size() == 0, "R2 discard no bus events", obs_q.size(), 0);
    chk(!scl_oe && !sda_oe && fifo_empty, "R2 discard lines idle", {scl_oe, sda_oe, fifo_empty}, 1);

    // R9 full queue drops extra push
    wr(1, 40); wr(2, 40);
    wr(0, 'h148);
    for (int i = 1; i < 8; i++) wr(0, i);
    wr(0, 'h208);
    chk(fifo_full == 1'b1, "R9 full after 8 words", fifo_full, 1);
    wr(0, 'h2FF);
    chk(fifo_full == 1'b1, "R9 still full after drop", fifo_full, 1);
    exp_q = '{EV_S, 'h48, 1, 2, 3, 4, 5, 6, 7, 8, EV_P};
    wait_quiet(300);
    compare("R9 dropped word absent");

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule